// File: doc/BRIEF.md
# Host Task Handshake Controller

This block is the host-facing task sequencer of a block-oriented modem data pump. A microcontroller talks to it through four byte-wide locations: a command location that takes a 3-bit task code, a data location that reaches a block buffer of up to 16 bytes, a status location, and a mode location. A task begins only when the host writes a non-null code to the command location. In transmit mode the task moves the block buffer into a downstream interleave FIFO. In receive mode it waits for received symbols to build up in a de-interleave FIFO and then packs them into the block buffer. The two FIFOs are outside the block and are seen only through count, push, pop and flush signals.

A buffer-free flag in the status register carries the handshake. A task write drops the flag. The flag comes back, together with an interrupt flag, once the block buffer has been emptied (transmit) or filled (receive). Because of this the host can load the next transmit block while the interleave FIFO is still sending the previous one. An active-low interrupt pin follows the interrupt flag when the mode register enables it.

The sequencer is a six-state machine. ST_IDLE goes to ST_TX_WAIT or ST_RX_WAIT on an accepted task, depending on the mode bit at the time of the write. ST_TX_WAIT goes to ST_TX_MOVE once the interleave FIFO has room for the whole block. ST_TX_MOVE pushes one byte per cycle and returns to ST_IDLE after the last byte. ST_RX_WAIT goes to ST_RX_HI once the de-interleave FIFO holds twice the block length in symbols. ST_RX_HI pops the high nibble and always moves to ST_RX_LO. ST_RX_LO pops the low nibble and writes the byte, then goes back to ST_RX_HI, or to ST_IDLE after the last byte. A RESET task sends every state to ST_IDLE.

Top module: `task_handshake_ctrl`

## Requirements
- R1: After reset, status reads 0x01 (bit 0 buffer-free = 1, bit 1 irq = 0, bit 2 error = 0) and irq_n is high. Locations: 0 command, 1 data, 2 status, 3 mode (bit 0 = 1 transmit / 0 receive, bit 1 = irq enable).
- R2: Writing a task code other than 0 (NULL) or 7 (RESET) while buffer-free is 1 clears buffer-free on the same clock edge.
- R3: In transmit mode, a task with code c in 1..6 pushes exactly L(c) bytes into the interleave FIFO, in the order byte 0 first, as the host wrote them. L = 1, 2, 4, 8, 12, 16 for c = 1..6.
- R4: Transmission starts only when ilv_free >= L. With room already present, buffer-free and irq both become 1 on the (L+1)-th edge after the command edge.
- R5: irq_n is low only while the irq flag is 1 and mode bit 1 is 1.
- R6: A status read clears the irq flag on that edge, which releases irq_n.
- R7: A task write while buffer-free is 0 is ignored and sets the sticky error flag. The running task keeps its own length.
- R8: Writing code 7 aborts any transfer, sets buffer-free to 1, clears irq and error, and pulses fifo_flush for one cycle.
- R9: Writing code 0 changes no flag and starts no transfer.
- R10: In receive mode, each byte j of the block is {symbol 2j, symbol 2j+1}, with the earlier symbol in the high nibble. Host reads return the bytes from byte 0 in order. Buffer-free and irq rise on the (2L+1)-th edge after the command edge when enough symbols are already present.
- R11: A receive task pops no symbol and keeps buffer-free at 0 until dil_count >= 2L. It completes 2L+1 edges after the count reaches that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (side effects on data and status locations) |
| host_addr | input | 2 | Host location select |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data, combinational from host_addr |
| irq_n | output | 1 | Active-low interrupt pin |
| ilv_wr | output | 1 | Push strobe into the interleave FIFO |
| ilv_data | output | DATA_W | Byte pushed into the interleave FIFO |
| ilv_free | input | CNT_W | Free entries in the interleave FIFO |
| dil_rd | output | 1 | Pop strobe from the de-interleave FIFO |
| dil_sym | input | SYM_W | Head symbol of the de-interleave FIFO |
| dil_count | input | CNT_W | Symbols held in the de-interleave FIFO |
| fifo_flush | output | 1 | One-cycle pulse telling both FIFOs to empty |

## Verification
If the state register or the byte index goes wrong, the interleave FIFO sees a different number of pushes, or the bytes land in the wrong order. The irq_n edge also moves away from its arithmetic position of L+1 or 2L+1 edges after the command. The bench sweeps every task length in both directions and counts edges up to that irq_n fall, so a fault shows within one task of at most 33 cycles. If a flag is stuck or fails to clear, the next status read shows it at once. A dropped RESET or rejected-task path shows as an extra push or a wrong length in the task that follows.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TX_WAIT,
        ST_TX_MOVE,
        ST_RX_WAIT,
        ST_RX_HI,
        ST_RX_LO
    } hs_state_e;

    localparam logic [2:0] TASK_NULL  = 3'd0;
    localparam logic [2:0] TASK_RESET = 3'd7;

    localparam logic [1:0] A_CMD  = 2'd0;
    localparam logic [1:0] A_DATA = 2'd1;
    localparam logic [1:0] A_STAT = 2'd2;
    localparam logic [1:0] A_MODE = 2'd3;

    localparam int LEN_W = 5;

    // block length in bytes selected by a task code
    function automatic logic [LEN_W-1:0] task_len(input logic [2:0] code);
        logic [LEN_W-1:0] n;
        case (code)
            3'd1:    n = 5'd1;
            3'd2:    n = 5'd2;
            3'd3:    n = 5'd4;
            3'd4:    n = 5'd8;
            3'd5:    n = 5'd12;
            3'd6:    n = 5'd16;
            default: n = 5'd0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/hs_block_buf.sv
module hs_block_buf #(
    parameter int DEPTH  = 16,
    parameter int AW     = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/hs_task_fsm.sv
module hs_task_fsm
    import hs_pkg::*;
#(
    parameter int AW    = 4,
    parameter int CNT_W = 6,
    parameter int SYM_W = 4,
    localparam int DATA_W = 2 * SYM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_tx,
    input  logic [LEN_W-1:0]  start_len,
    input  logic              abort,
    input  logic [CNT_W-1:0]  ilv_free,
    input  logic [CNT_W-1:0]  dil_count,
    input  logic [SYM_W-1:0]  dil_sym,
    input  logic [DATA_W-1:0] buf_rdata,
    output logic [AW-1:0]     eng_addr,
    output logic              eng_we,
    output logic [DATA_W-1:0] eng_wdata,
    output logic              ilv_wr,
    output logic [DATA_W-1:0] ilv_data,
    output logic              dil_rd,
    output logic              done,
    output logic              busy
);

    hs_state_e         state_q, state_d;
    logic [LEN_W-1:0]  len_q;
    logic [AW-1:0]     idx_q;
    logic [SYM_W-1:0]  hi_q;
    logic              last;
    logic              tx_room;
    logic              rx_ready;

    assign last     = (idx_q == AW'(len_q - 5'd1));
    assign tx_room  = (ilv_free  >= CNT_W'(len_q));
    assign rx_ready = (dil_count >= CNT_W'({len_q, 1'b0}));

    // next state
    always_comb begin
        state_d = state_q;
        if (abort) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:    if (start)    state_d = start_tx ? ST_TX_WAIT : ST_RX_WAIT;
                ST_TX_WAIT: if (tx_room)  state_d = ST_TX_MOVE;
                ST_TX_MOVE: if (last)     state_d = ST_IDLE;
                ST_RX_WAIT: if (rx_ready) state_d = ST_RX_HI;
                ST_RX_HI:                 state_d = ST_RX_LO;
                ST_RX_LO:                 state_d = last ? ST_IDLE : ST_RX_HI;
                default:                  state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // length, byte index and pending high nibble
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
            idx_q <= '0;
            hi_q  <= '0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                len_q <= start_len;
                idx_q <= '0;
            end
            if (state_q == ST_TX_MOVE || state_q == ST_RX_LO) begin
                idx_q <= idx_q + 1'b1;
            end
            if (state_q == ST_RX_HI) begin
                hi_q <= dil_sym;
            end
        end
    end

    // outputs
    always_comb begin
        ilv_wr    = (state_q == ST_TX_MOVE);
        ilv_data  = buf_rdata;
        dil_rd    = (state_q == ST_RX_HI) || (state_q == ST_RX_LO);
        eng_we    = (state_q == ST_RX_LO);
        eng_wdata = {hi_q, dil_sym};
        eng_addr  = idx_q;
        done      = ((state_q == ST_TX_MOVE) || (state_q == ST_RX_LO)) && last && !abort;
        busy      = (state_q != ST_IDLE);
    end

endmodule

// File: rtl/task_handshake_ctrl.sv
module task_handshake_ctrl
    import hs_pkg::*;
#(
    parameter int BUF_DEPTH = 16,
    parameter int CNT_W     = 6,
    parameter int SYM_W     = 4,
    localparam int AW       = $clog2(BUF_DEPTH),
    localparam int DATA_W   = 2 * SYM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [1:0]        host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              irq_n,
    output logic              ilv_wr,
    output logic [DATA_W-1:0] ilv_data,
    input  logic [CNT_W-1:0]  ilv_free,
    output logic              dil_rd,
    input  logic [SYM_W-1:0]  dil_sym,
    input  logic [CNT_W-1:0]  dil_count,
    output logic              fifo_flush
);

    logic [1:0]        mode_q;
    logic              bfree_q, irq_q, err_q, flush_q;
    logic [AW-1:0]     host_ptr;

    logic              cmd_wr, cmd_reset, cmd_task, accept, reject;
    logic              stat_rd, data_wr, data_rd;
    logic [2:0]        code;

    logic [AW-1:0]     eng_addr;
    logic              eng_we, done, busy;
    logic [DATA_W-1:0] eng_wdata, buf_rdata;

    logic              buf_we;
    logic [AW-1:0]     buf_waddr, buf_raddr;
    logic [DATA_W-1:0] buf_wdata;

    assign code      = host_wdata[2:0];
    assign cmd_wr    = host_wr && (host_addr == A_CMD);
    assign cmd_reset = cmd_wr && (code == TASK_RESET);
    assign cmd_task  = cmd_wr && (code != TASK_NULL) && (code != TASK_RESET);
    assign accept    = cmd_task && bfree_q;
    assign reject    = cmd_task && !bfree_q;
    assign stat_rd   = host_rd && (host_addr == A_STAT);
    assign data_wr   = host_wr && (host_addr == A_DATA) && bfree_q;
    assign data_rd   = host_rd && (host_addr == A_DATA) && bfree_q;

    hs_task_fsm #(
        .AW    (AW),
        .CNT_W (CNT_W),
        .SYM_W (SYM_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .start_tx  (mode_q[0]),
        .start_len (task_len(code)),
        .abort     (cmd_reset),
        .ilv_free  (ilv_free),
        .dil_count (dil_count),
        .dil_sym   (dil_sym),
        .buf_rdata (buf_rdata),
        .eng_addr  (eng_addr),
        .eng_we    (eng_we),
        .eng_wdata (eng_wdata),
        .ilv_wr    (ilv_wr),
        .ilv_data  (ilv_data),
        .dil_rd    (dil_rd),
        .done      (done),
        .busy      (busy)
    );

    // the engine owns the buffer while a task runs, the host otherwise
    assign buf_we    = eng_we || data_wr;
    assign buf_waddr = eng_we ? eng_addr  : host_ptr;
    assign buf_wdata = eng_we ? eng_wdata : host_wdata;
    assign buf_raddr = busy   ? eng_addr  : host_ptr;

    hs_block_buf #(
        .DEPTH  (BUF_DEPTH),
        .AW     (AW),
        .DATA_W (DATA_W)
    ) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .waddr (buf_waddr),
        .wdata (buf_wdata),
        .raddr (buf_raddr),
        .rdata (buf_rdata)
    );

    // host-visible flags and sequential pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= '0;
            bfree_q  <= 1'b1;
            irq_q    <= 1'b0;
            err_q    <= 1'b0;
            flush_q  <= 1'b0;
            host_ptr <= '0;
        end else begin
            flush_q <= cmd_reset;
            if (host_wr && host_addr == A_MODE) begin
                mode_q <= host_wdata[1:0];
            end
            if (cmd_reset) begin
                bfree_q  <= 1'b1;
                irq_q    <= 1'b0;
                err_q    <= 1'b0;
                host_ptr <= '0;
            end else begin
                if (accept) begin
                    bfree_q  <= 1'b0;
                    host_ptr <= '0;
                end else if (done) begin
                    bfree_q  <= 1'b1;
                    host_ptr <= '0;
                end else if (data_wr || data_rd) begin
                    host_ptr <= host_ptr + 1'b1;
                end
                if (done) begin
                    irq_q <= 1'b1;
                end else if (stat_rd) begin
                    irq_q <= 1'b0;
                end
                if (reject) begin
                    err_q <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        host_rdata = '0;
        case (host_addr)
            A_DATA:  if (bfree_q) host_rdata = buf_rdata;
            A_STAT:  host_rdata[2:0] = {err_q, irq_q, bfree_q};
            A_MODE:  host_rdata[1:0] = mode_q;
            default: host_rdata = '0;
        endcase
    end

    assign irq_n      = !(irq_q && mode_q[1]);
    assign fifo_flush = flush_q;

endmodule

// File: rtl/hs_ctrl_checker.sv
module hs_ctrl_checker
    import hs_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_wr,
    input logic [1:0]       host_addr,
    input logic [2:0]       host_code,
    input logic             bfree_q,
    input logic             irq_q,
    input logic             err_q,
    input logic             ilv_wr,
    input logic             dil_rd,
    input logic [CNT_W-1:0] dil_count
);

    logic rst_cmd, task_cmd;
    assign rst_cmd  = host_wr && (host_addr == A_CMD) && (host_code == TASK_RESET);
    assign task_cmd = host_wr && (host_addr == A_CMD) &&
                      (host_code != TASK_NULL) && (host_code != TASK_RESET);

    a_r2_task_clears_free: assert property (@(posedge clk) disable iff (!rst_n)
        (task_cmd && bfree_q) |=> !bfree_q);

    a_r4_free_return_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (!bfree_q && !rst_cmd) |=> (!bfree_q || irq_q));

    a_r3_no_push_while_free: assert property (@(posedge clk) disable iff (!rst_n)
        bfree_q |-> !ilv_wr);

    a_r11_pop_needs_symbol: assert property (@(posedge clk) disable iff (!rst_n)
        dil_rd |-> (dil_count != '0));

    a_r7_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !rst_cmd) |=> err_q);

    a_r8_reset_task_frees: assert property (@(posedge clk) disable iff (!rst_n)
        rst_cmd |=> (bfree_q && !irq_q && !err_q));

endmodule

bind task_handshake_ctrl hs_ctrl_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_wr   (host_wr),
    .host_addr (host_addr),
    .host_code (host_wdata[2:0]),
    .bfree_q   (bfree_q),
    .irq_q     (irq_q),
    .err_q     (err_q),
    .ilv_wr    (ilv_wr),
    .dil_rd    (dil_rd),
    .dil_count (dil_count)
);

// File: tb/task_handshake_ctrl_tb.sv
`timescale 1ns/1ps
module task_handshake_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [1:0] host_addr = 2'd0;
    logic [7:0] host_wdata = 8'd0;
    logic [7:0] host_rdata;
    logic       irq_n;
    logic       ilv_wr;
    logic [7:0] ilv_data;
    logic [5:0] ilv_free = 6'd32;
    logic       dil_rd;
    logic [3:0] dil_sym;
    logic [5:0] dil_count;
    logic       fifo_flush;

    logic [3:0] dil_mem [0:63];
    logic [5:0] dil_wp = 6'd0;
    logic [5:0] dil_rp = 6'd0;
    logic [7:0] ilv_log [0:255];
    int         ilv_n = 0;
    int         flush_n = 0;
    int         n_chk = 0;
    int         n_fail = 0;

    always #2.5 clk = ~clk;

    assign dil_sym   = dil_mem[dil_rp];
    assign dil_count = dil_wp - dil_rp;

    task_handshake_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .irq_n      (irq_n),
        .ilv_wr     (ilv_wr),
        .ilv_data   (ilv_data),
        .ilv_free   (ilv_free),
        .dil_rd     (dil_rd),
        .dil_sym    (dil_sym),
        .dil_count  (dil_count),
        .fifo_flush (fifo_flush)
    );

    // de-interleave FIFO model: pops take effect on the edge
    always @(posedge clk) begin
        if (fifo_flush)  dil_rp <= dil_wp;
        else if (dil_rd) dil_rp <= dil_rp + 6'd1;
    end

    // interleave FIFO model and flush counter
    always @(negedge clk) begin
        if (ilv_wr) begin
            ilv_log[ilv_n[7:0]] = ilv_data;
            ilv_n = ilv_n + 1;
        end
        if (fifo_flush) flush_n = flush_n + 1;
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic hwrite(input logic [1:0] a, input logic [7:0] d);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(input logic [1:0] a, output logic [7:0] d);
        host_rd = 1'b1; host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic peek_status(output logic [7:0] d);
        host_addr = 2'd2;
        #1 d = host_rdata;
    endtask

    task automatic push_sym(input logic [3:0] s);
        dil_mem[dil_wp] = s;
        dil_wp = dil_wp + 6'd1;
    endtask

    task automatic wait_irq(output int lat);
        lat = 0;
        while (irq_n && lat < 100) begin
            @(negedge clk);
            lat = lat + 1;
        end
    endtask

    function automatic int blen(input int c);
        return (c <= 4) ? (1 << (c - 1)) : (c - 2) * 4;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail = n_fail + 1;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        int lat, base, sbase;
        tick(4);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        hread(2'd2, v);
        check("R1 status after reset", v, 1);
        check("R1 irq_n after reset", irq_n, 1);

        // transmit sweep, irq enabled
        hwrite(2'd3, 8'h03);
        for (int c = 1; c <= 6; c++) begin
            ilv_free = 6'd32;
            for (int i = 0; i < blen(c); i++) hwrite(2'd1, 8'(c * 16 + i * 7));
            base = ilv_n;
            hwrite(2'd0, 8'(c));
            peek_status(v);
            check("R2 buffer-free cleared by task", v[0], 0);
            wait_irq(lat);
            check("R4 transmit completion latency", lat, blen(c) + 1);
            check("R3 transmit byte count", ilv_n - base, blen(c));
            for (int i = 0; i < blen(c); i++)
                check("R3 transmit byte value", ilv_log[8'(base + i)], (c * 16 + i * 7) % 256);
            hread(2'd2, v);
            check("R4 status after transmit", v, 3);
            check("R6 irq_n released by status read", irq_n, 1);
            peek_status(v);
            check("R6 irq flag cleared", v[1], 0);
        end

        // stall on lack of room, rejected task while busy
        ilv_free = 6'd3;
        for (int i = 0; i < 4; i++) hwrite(2'd1, 8'(8'hA0 + i));
        base = ilv_n;
        hwrite(2'd0, 8'd3);
        tick(8);
        check("R4 no push without room", ilv_n - base, 0);
        hwrite(2'd0, 8'd2);
        peek_status(v);
        check("R7 rejected task sets error", v, 4);
        ilv_free = 6'd4;
        wait_irq(lat);
        check("R7 running task keeps length", ilv_n - base, 4);
        check("R3 stalled byte order", ilv_log[8'(base + 3)], 8'hA3);
        hread(2'd2, v);
        check("R7 error sticky after completion", v, 7);

        // RESET clears the error and pulses flush
        sbase = flush_n;
        hwrite(2'd0, 8'd7);
        tick(1);
        peek_status(v);
        check("R8 status after reset task", v, 1);
        check("R8 flush pulse", flush_n - sbase, 1);

        // RESET during a stalled transfer
        ilv_free = 6'd0;
        for (int i = 0; i < 8; i++) hwrite(2'd1, 8'(i));
        base = ilv_n;
        hwrite(2'd0, 8'd4);
        tick(3);
        hwrite(2'd0, 8'd7);
        ilv_free = 6'd32;
        tick(6);
        check("R8 aborted task pushes nothing", ilv_n - base, 0);
        peek_status(v);
        check("R8 buffer free after abort", v, 1);

        // NULL has no effect
        hwrite(2'd1, 8'h55);
        hwrite(2'd0, 8'd0);
        tick(5);
        check("R9 null starts no transfer", ilv_n - base, 0);
        peek_status(v);
        check("R9 null leaves flags", v, 1);

        // irq pin gated by enable
        hwrite(2'd3, 8'h01);
        hwrite(2'd0, 8'd7);
        hwrite(2'd1, 8'h3C);
        hwrite(2'd0, 8'd1);
        tick(6);
        check("R5 irq_n high with enable off", irq_n, 1);
        peek_status(v);
        check("R5 irq flag still set", v, 3);
        check("R3 single byte value", ilv_log[8'(ilv_n - 1)], 8'h3C);
        hwrite(2'd3, 8'h03);
        tick(1);
        check("R5 irq_n low once enabled", irq_n, 0);
        hread(2'd2, v);

        // receive sweep
        hwrite(2'd3, 8'h02);
        for (int c = 1; c <= 6; c++) begin
            for (int j = 0; j < 2 * blen(c); j++) push_sym(4'((c * 3 + j * 5) % 16));
            hwrite(2'd0, 8'(c));
            peek_status(v);
            check("R2 buffer-free cleared in receive", v[0], 0);
            wait_irq(lat);
            check("R10 receive completion latency", lat, 2 * blen(c) + 1);
            check("R10 all symbols consumed", dil_count, 0);
            hread(2'd2, v);
            check("R10 status after receive", v, 3);
            for (int i = 0; i < blen(c); i++) begin
                hread(2'd1, v);
                check("R10 received byte", v,
                      ((c * 3 + 2 * i * 5) % 16) * 16 + (c * 3 + (2 * i + 1) * 5) % 16);
            end
        end

        // receive waits for enough symbols
        push_sym(4'h9); push_sym(4'h1); push_sym(4'hE);
        hwrite(2'd0, 8'd2);
        tick(10);
        peek_status(v);
        check("R11 waiting keeps buffer busy", v[0], 0);
        check("R11 no pop before enough symbols", dil_count, 3);
        push_sym(4'h6);
        wait_irq(lat);
        check("R11 latency after last symbol", lat, 5);
        hread(2'd2, v);
        hread(2'd1, v);
        check("R11 first byte", v, 8'h91);
        hread(2'd1, v);
        check("R11 second byte", v, 8'hE6);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule